// File: doc/BRIEF.md
# Sliding Window Line Buffer

This block turns a raster-ordered pixel stream into square K×K neighbourhoods, one per accepted pixel, for a downstream window operator. Every pixel inside the current window sits in its own register and all K×K values are presented in parallel. The part of each image row that lies outside the window waits in a shift-register delay line. The total storage is exactly (K−1)·N + K pixels for an image N pixels wide.

A per-pixel enable moves the stream forward. While the enable is high, each clock accepts one pixel, slides the window by one position and presents a new window. While it is low, nothing moves. Counters follow the column and the position within the frame. A start-of-frame strobe resynchronises them. An output flag marks windows that have filled completely within the current frame. A per-column mask, also output, marks window columns whose pixels come from the wrong image row near the left and right edges. Those columns are driven as zero.

Top module: `swin_linebuf`

## Requirements
- R1: After a synchronous active-low reset, `active_o` is 0, `col_mask_o` is all zero and `win_o` is all zero.
- R2: After an accept, window entry (r, c) holds the pixel accepted (K−1−r)·N + (K−1−c) accepts earlier. Row r=0 is the oldest row and column c=0 is the oldest column. The shift chain therefore holds exactly (K−1)·N + K pixels.
- R3: An accept with `en_i` high shifts every stored pixel by one place and loads `pix_i` into entry (K−1, K−1). With `en_i` low, `win_o`, `col_mask_o` and `active_o` keep their values.
- R4: `active_o` becomes 1 with the accept of the frame pixel whose index is L−1 = (K−1)·N + K − 1, counted from 0. This is the pixel at row K−1, column K−1. The flag stays 1 for every later accept of that frame.
- R5: After accepting a pixel at column x, `col_mask_o[c]` is 1 exactly when x + c ≥ K−1. The masked-off columns are the leftmost ones.
- R6: An accept with `sof_i` high treats the pixel as column 0, index 0 of a new frame, so `active_o` drops to 0. Without the strobe, the position wraps to index 0 after N·H accepts and the fill latency is paid again.
- R7: Entry (r, c) is output on `win_o[(r·K + c)·W +: W]`. An entry whose column mask bit is 0 is output as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Accept `pix_i` this cycle and advance |
| sof_i | input | 1 | First pixel of a frame (qualified by `en_i`) |
| pix_i | input | W | Incoming pixel |
| win_o | output | K·K·W | Window entries, row-major, column-masked |
| col_mask_o | output | K | Per-column valid flag |
| active_o | output | 1 | Window fully filled within the current frame |

## Verification
The first stream is an unbroken frame of pseudo-random values. It shows that each window entry comes from the right delay, that the fill point is exact and that one window is delivered per clock. A second frame has idle cycles between pixels. It separates a shift tied to the enable from one tied to the clock, because a frozen window must repeat the previous expectation exactly. A frame is cut short by an early start-of-frame strobe and is followed by a frame that wraps on its own count. Together these two cases tell a counter resynchronisation apart from a natural wrap, and both must pay the fill latency again. Every row start exercises the edge mask in both of its partial-width patterns.

// File: rtl/swin_pkg.sv
// Package: shared helpers for the sliding window line buffer.
// Assumes K >= 2 and an image width larger than K.
package swin_pkg;

    // Number of pixel slots needed to expose a k x k window over n-wide rows.
    function automatic int fill_latency(input int k, input int n);
        return (k - 1) * n + k;
    endfunction

endpackage

// File: rtl/swin_delay_line.sv
// Module: fixed-length shift register carrying the off-window part of a row.
// Assumes DEPTH >= 1; contents move only when en is high; data is not reset.
module swin_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    // Shift one place toward the tail on each accepted pixel.
    always_ff @(posedge clk) begin
        if (en) begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

    AST_DL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout)); // R3
endmodule

// File: rtl/swin_pos_ctrl.sv
// Module: tracks column and in-frame index, raises the fill flag and builds
// the edge column mask. Assumes IMG_H >= K so the fill point lies in a frame.
module swin_pos_ctrl
    import swin_pkg::*;
#(
    parameter int K     = 3,
    parameter int IMG_W = 8,
    parameter int IMG_H = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         sof,
    output logic [K-1:0] col_mask,
    output logic         active
);
    localparam int FRAME = IMG_W * IMG_H;
    localparam int L     = fill_latency(K, IMG_W);
    localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int IDX_W = (FRAME > 1) ? $clog2(FRAME) : 1;
    localparam logic [COL_W-1:0] COL_LAST  = COL_W'(IMG_W - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME - 1);
    localparam logic [IDX_W-1:0] FILL_LAST = IDX_W'(L - 1);

    logic [COL_W-1:0] col_q, cur_col;
    logic [IDX_W-1:0] idx_q, cur_idx;
    logic [K-1:0]     mask_d;

    // Position of the pixel offered now; a frame strobe forces the origin.
    always_comb begin
        cur_col = sof ? '0 : col_q;
        cur_idx = sof ? '0 : idx_q;
    end

    // Column c is valid when it lies in the same image row as the newest pixel.
    always_comb begin
        for (int c = 0; c < K; c++) begin
            mask_d[c] = (int'(cur_col) + c >= K - 1);
        end
    end

    // Advance the counters and register the flag and mask on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q    <= '0;
            idx_q    <= '0;
            col_mask <= '0;
            active   <= 1'b0;
        end else if (en) begin
            col_q    <= (cur_col == COL_LAST) ? '0 : cur_col + 1'b1;
            idx_q    <= (cur_idx == IDX_LAST) ? '0 : cur_idx + 1'b1;
            col_mask <= mask_d;
            active   <= (cur_idx >= FILL_LAST);
        end
    end

    AST_CTRL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(active) && $stable(col_mask))); // R3
    AST_ACTIVE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(en)); // R4
    AST_NEWEST_COL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> col_mask[K-1]); // R4
    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sof) |=> !active); // R6
    AST_MASK_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((~col_mask) & ((~col_mask) + 1'b1)) == '0); // R5
endmodule

// File: rtl/swin_linebuf.sv
// Module: top of the sliding window line buffer. K x K window registers are
// chained through K-1 delay lines of IMG_W-K stages, giving (K-1)*IMG_W+K slots.
// Assumes K >= 2, IMG_W > K, IMG_H >= K. Window data is not reset; the mask
// gates it to zero until it has been loaded.
module swin_linebuf #(
    parameter int K     = 3,
    parameter int IMG_W = 8,
    parameter int IMG_H = 5,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sof_i,
    input  logic [W-1:0]     pix_i,
    output logic [K*K*W-1:0] win_o,
    output logic [K-1:0]     col_mask_o,
    output logic             active_o
);
    localparam int DL_DEPTH = IMG_W - K;

    logic [W-1:0] win_q  [K][K];
    logic [W-1:0] dl_out [K-1];

    // One delay line per row pair: takes the oldest column of row r+1.
    for (genvar r = 0; r < K - 1; r++) begin : g_row_dl
        swin_delay_line #(.W(W), .DEPTH(DL_DEPTH)) u_dl (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en_i),
            .din  (win_q[r+1][0]),
            .dout (dl_out[r])
        );
    end

    // Slide the window left one column per accepted pixel.
    always_ff @(posedge clk) begin
        if (en_i) begin
            for (int r = 0; r < K; r++) begin
                for (int c = 0; c < K; c++) begin
                    if (c < K - 1)      win_q[r][c] <= win_q[r][c+1];
                    else if (r < K - 1) win_q[r][c] <= dl_out[r];
                    else                win_q[r][c] <= pix_i;
                end
            end
        end
    end

    swin_pos_ctrl #(.K(K), .IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_i),
        .sof     (sof_i),
        .col_mask(col_mask_o),
        .active  (active_o)
    );

    // Pack the window row-major and zero the columns that wrap a row.
    always_comb begin
        for (int r = 0; r < K; r++) begin
            for (int c = 0; c < K; c++) begin
                win_o[(r*K+c)*W +: W] = col_mask_o[c] ? win_q[r][c] : '0;
            end
        end
    end

    AST_NEWEST_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (win_q[K-1][K-1] == $past(pix_i))); // R3
    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(win_o)); // R3
endmodule

// File: tb/swin_linebuf_tb.sv
module swin_linebuf_tb_top;
    localparam int K = 3, N = 8, H = 5, W = 8;
    localparam int FRAME = N * H;
    localparam int L = (K - 1) * N + K;

    typedef struct {
        bit               hold;
        bit               fstart;
        logic             act;
        logic [K-1:0]     mask;
        logic [K*K*W-1:0] win;
        logic [K*K-1:0]   known;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0, sof_i = 1'b0;
    logic [W-1:0] pix_i = '0;
    logic [K*K*W-1:0] win_o;
    logic [K-1:0] col_mask_o;
    logic active_o;

    int tests = 0, fails = 0;
    int hist[$];
    int mcol = 0, midx = 0;
    exp_t exp_q[$];
    exp_t last;

    always #10 clk = ~clk;

    swin_linebuf #(.K(K), .IMG_W(N), .IMG_H(H), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .sof_i(sof_i), .pix_i(pix_i),
        .win_o(win_o), .col_mask_o(col_mask_o), .active_o(active_o)
    );

    // Driver: offer one pixel and push the expected result of its accept.
    task automatic accept(input int p, input bit sof);
        exp_t e;
        @(negedge clk);
        en_i = 1'b1; sof_i = sof; pix_i = W'(p);
        if (sof) begin mcol = 0; midx = 0; end
        hist.push_back(p);
        e.hold = 1'b0;
        e.fstart = (midx == 0);
        e.act = (midx >= L - 1);
        e.win = '0; e.known = '0;
        for (int c = 0; c < K; c++) e.mask[c] = (mcol + c >= K - 1);
        for (int r = 0; r < K; r++) begin
            for (int c = 0; c < K; c++) begin
                int back, idx;
                back = (K - 1 - r) * N + (K - 1 - c);
                idx = hist.size() - 1 - back;
                if (!e.mask[c]) e.known[r*K+c] = 1'b1;
                else if (idx >= 0) begin
                    e.win[(r*K+c)*W +: W] = W'(hist[idx]);
                    e.known[r*K+c] = 1'b1;
                end
            end
        end
        exp_q.push_back(e);
        last = e;
        mcol = (mcol == N - 1) ? 0 : mcol + 1;
        midx = (midx == FRAME - 1) ? 0 : midx + 1;
    endtask

    // Driver: one cycle with the enable low; outputs must repeat.
    task automatic idle();
        exp_t e;
        @(negedge clk);
        en_i = 1'b0; sof_i = 1'b0; pix_i = 8'hEE;
        e = last;
        e.hold = 1'b1;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the outputs one time step after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = exp_q.pop_front();
            tests++;
            if (active_o !== e.act) begin
                fails++;
                $display("FAIL %s active: got %0b expected %0b",
                         e.hold ? "R3" : (e.fstart ? "R6" : "R4"), active_o, e.act);
            end
            tests++;
            if (col_mask_o !== e.mask) begin
                fails++;
                $display("FAIL %s mask: got %b expected %b",
                         e.hold ? "R3" : "R5", col_mask_o, e.mask);
            end
            tests++;
            bad = 1'b0;
            for (int i = 0; i < K * K; i++)
                if (e.known[i] && win_o[i*W +: W] !== e.win[i*W +: W]) bad = 1'b1;
            if (bad) begin
                fails++;
                $display("FAIL %s window: got %h expected %h (known %b)",
                         e.hold ? "R3" : "R2/R7", win_o, e.win, e.known);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        tests++;
        if (active_o !== 1'b0 || col_mask_o !== '0 || win_o !== '0) begin
            fails++;
            $display("FAIL R1 reset: got %0b %b %h expected 0 0 0",
                     active_o, col_mask_o, win_o);
        end
        @(negedge clk); rst_n = 1'b1;
        // Unbroken frame with scrambled values (R2, R4, R5)
        for (int i = 0; i < FRAME; i++) accept((i * 37 + 11) & 255, i == 0);
        // Frame with idle gaps (R3)
        for (int i = 0; i < FRAME; i++) begin
            accept(i ^ 8'hA5, i == 0);
            if (i % 3 == 1) idle();
            if (i % 7 == 4) idle();
        end
        // Short frame cut by an early strobe (R6)
        for (int i = 0; i < 21; i++) accept((i * 5 + 200) & 255, i == 0);
        for (int i = 0; i < FRAME; i++) accept(255 - i, i == 0);
        // Natural wrap into the next frame without a strobe (R6)
        for (int i = 0; i < 2 * N + 4; i++) accept((i * 11) & 255, 1'b0);
        @(negedge clk); en_i = 1'b0; sof_i = 1'b0;
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule